// File: doc/BRIEF.md
# SMBus Inactivity Timeout and Packet Error Check Unit

This unit sits next to an SMBus/I2C slave engine and watches the byte-level traffic that engine reports. It provides two services. The first is a CRC-8 over every byte of a transaction, address bytes included. On a write, the unit compares the optional check byte sent by the master against that CRC and flags a mismatch. On a read, it offers the CRC as the byte to shift out. The second is an optional bus inactivity timeout. When it is enabled and a transaction has been open too long without any SCL or SDA transition, the unit sends a one-cycle reset pulse to the slave engine.

The slave engine reports start conditions (repeated starts included), stop conditions, each completed byte, the transfer direction, and whether the current byte is the extra check byte that comes after the last data byte. Bit-level line handling stays in the slave engine. The timeout length comes from the system clock frequency and a millisecond parameter. The enable input is meant to be driven by a configuration bit whose power-on value is 0, so the timeout is off by default.

Top module: `smb_pec_guard`

## Requirements
- R1: After reset, `crc_o` is 0x00 and `to_rst_o`, `pec_match_o` and `pec_err_o` are 0.
- R2: Each completed byte with `pec_slot_i`=0 updates `crc_o` on the next clock edge. The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, no final XOR, and processes the MSB first. The nine ASCII bytes "123456789" give 0xF4.
- R3: `start_i` clears `crc_o` to 0x00 and clears `pec_err_o` on the next edge. A byte strobed in the same cycle as `start_i` is discarded.
- R4: A write check byte (`byte_vld_i`=1, `pec_slot_i`=1, `rd_i`=0) that equals `crc_o` raises `pec_match_o` for exactly one cycle after the next edge. Any check byte leaves `crc_o` unchanged.
- R5: A write check byte that differs from `crc_o` sets `pec_err_o` on the next edge. The flag stays set until the next `start_i` or timeout pulse, even while further bytes arrive.
- R6: `pec_tx_o` equals `crc_o` while `rd_i`=1 and is 0x00 while `rd_i`=0. A check byte received while `rd_i`=1 changes neither `crc_o` nor the flags.
- R7: While `to_en_i`=0, `to_rst_o` never rises.
- R8: With `to_en_i`=1 and a transaction open, `to_rst_o` is high for one cycle after TO_CYC consecutive clock edges with no `bus_edge_i`, counted from the edge that took `start_i` or the last `bus_edge_i`. TO_CYC = CLK_HZ/1000*TO_MS.
- R9: A `bus_edge_i` pulse restarts the inactivity count from zero.
- R10: The timeout counts only between a start and a stop. After `stop_i` or a timeout pulse, no further pulse occurs until the next `start_i`.
- R11: In the cycle after a timeout pulse, `crc_o` is 0x00 and `pec_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| to_en_i | input | 1 | Inactivity timeout enable (configuration bit, 0 at power-on) |
| bus_edge_i | input | 1 | Strobe: any SCL or SDA transition seen |
| start_i | input | 1 | Strobe: start or repeated start condition |
| stop_i | input | 1 | Strobe: stop condition |
| byte_vld_i | input | 1 | Strobe: a byte completed on the bus |
| byte_i | input | 8 | Value of the completed byte |
| pec_slot_i | input | 1 | Current byte is the check byte after the last data byte |
| rd_i | input | 1 | Transfer direction: 1 = slave transmits (read) |
| to_rst_o | output | 1 | One-cycle reset pulse to the slave engine |
| crc_o | output | 8 | Running CRC of the current transaction |
| pec_tx_o | output | 8 | Check byte to transmit on reads |
| pec_match_o | output | 1 | Pulse: received check byte matched |
| pec_err_o | output | 1 | Sticky: received check byte mismatched |

## Verification
The CRC path is tested in three ways. A fixed ASCII string confirms the polynomial, the bit order and the initial value, which a random trace alone could leave ambiguous. Random-length transactions of random bytes are then compared against a bench model after every byte. Each of these transactions ends in one of three ways: a correct write check byte, a corrupted write check byte, or a read check byte. These endings separate the match pulse, the sticky error and the read path that must stay quiet. Mid-transaction repeated starts and a start colliding with a byte strobe test the clearing priority. The timeout is tested with a disabled enable, a bare idle window, an idle window broken by a bus edge, and idle time after a stop. These cases distinguish the exact firing cycle, a count restart and the disarming rules.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // one byte through the CRC, MSB first
  function automatic byte_t crc_step(input byte_t crc, input byte_t data, input byte_t poly);
    byte_t c;
    c = crc ^ data;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned TO_MS  = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic edge_i,
  output logic fire_o
);
  localparam int unsigned TO_CYC = (CLK_HZ / 1000) * TO_MS;
  localparam int unsigned CNT_W  = $clog2(TO_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             hit;

  assign hit = busy_q && en_i && !edge_i && !start_i && !stop_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (stop_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (hit) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        fire_q <= 1'b1;
      end else if (!busy_q || !en_i || edge_i) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/smb_crc_unit.sv
module smb_crc_unit
  import smb_pec_pkg::*;
#(
  parameter byte_t POLY = 8'h07,
  parameter byte_t INIT = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  upd_i,
  input  byte_t data_i,
  output byte_t crc_o
);
  byte_t crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (clr_i)  crc_q <= INIT;
    else if (upd_i)  crc_q <= crc_step(crc_q, data_i, POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/smb_pec_guard.sv
module smb_pec_guard
  import smb_pec_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned TO_MS  = 25,
  parameter byte_t       POLY   = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       to_en_i,
  input  logic       bus_edge_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       pec_slot_i,
  input  logic       rd_i,
  output logic       to_rst_o,
  output logic [7:0] crc_o,
  output logic [7:0] pec_tx_o,
  output logic       pec_match_o,
  output logic       pec_err_o
);
  logic  clr, upd, chk;
  byte_t crc;
  logic  match_q, err_q;

  smb_idle_timer #(.CLK_HZ(CLK_HZ), .TO_MS(TO_MS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (to_en_i),
    .start_i(start_i),
    .stop_i (stop_i),
    .edge_i (bus_edge_i),
    .fire_o (to_rst_o)
  );

  // start and timeout win over a byte in the same cycle
  assign clr = start_i || to_rst_o;
  assign upd = byte_vld_i && !pec_slot_i && !clr;
  assign chk = byte_vld_i && pec_slot_i && !rd_i && !clr;

  smb_crc_unit #(.POLY(POLY), .INIT(8'h00)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .upd_i (upd),
    .data_i(byte_i),
    .crc_o (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      match_q <= chk && (byte_i == crc);
      if (clr)                        err_q <= 1'b0;
      else if (chk && byte_i != crc)  err_q <= 1'b1;
    end
  end

  assign crc_o       = crc;
  assign pec_tx_o    = rd_i ? crc : 8'h00;
  assign pec_match_o = match_q;
  assign pec_err_o   = err_q;
endmodule

// File: rtl/smb_pec_guard_chk.sv
module smb_pec_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       to_en_i,
  input logic       bus_edge_i,
  input logic       start_i,
  input logic       byte_vld_i,
  input logic       pec_slot_i,
  input logic       to_rst_o,
  input logic [7:0] crc_o,
  input logic       pec_match_o,
  input logic       pec_err_o
);
  AST_START_CLR_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (crc_o == 8'h00)); // R3
  AST_START_CLR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pec_err_o); // R3
  AST_SLOT_HOLDS_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && pec_slot_i && !start_i && !to_rst_o) |=> $stable(crc_o)); // R4
  AST_ERR_NOT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pec_err_o) |-> !pec_match_o); // R5
  AST_TO_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_rst_o |-> $past(to_en_i)); // R7
  AST_TO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_rst_o |=> !to_rst_o); // R8
  AST_EDGE_NO_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_edge_i |=> !to_rst_o); // R9
  AST_TO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_rst_o |=> (crc_o == 8'h00 && !pec_err_o)); // R11
endmodule

bind smb_pec_guard smb_pec_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .to_en_i    (to_en_i),
  .bus_edge_i (bus_edge_i),
  .start_i    (start_i),
  .byte_vld_i (byte_vld_i),
  .pec_slot_i (pec_slot_i),
  .to_rst_o   (to_rst_o),
  .crc_o      (crc_o),
  .pec_match_o(pec_match_o),
  .pec_err_o  (pec_err_o)
);

// File: tb/tb_smb_pec_guard.sv
module tb_smb_pec_guard;
  localparam int unsigned CLK_HZ = 20_000;
  localparam int unsigned TO_MS  = 1;
  localparam int N = (CLK_HZ / 1000) * TO_MS;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic to_en, bus_edge, start, stop, bvld, slot, rd;
  logic [7:0] bdat;
  logic to_rst, pmatch, perr;
  logic [7:0] crc, ptx;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smb_pec_guard #(.CLK_HZ(CLK_HZ), .TO_MS(TO_MS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .to_en_i(to_en), .bus_edge_i(bus_edge),
    .start_i(start), .stop_i(stop), .byte_vld_i(bvld), .byte_i(bdat),
    .pec_slot_i(slot), .rd_i(rd), .to_rst_o(to_rst), .crc_o(crc),
    .pec_tx_o(ptx), .pec_match_o(pmatch), .pec_err_o(perr)
  );

  function automatic logic [7:0] m_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1; bus_edge = 1;
    @(negedge clk); start = 0; bus_edge = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1; bus_edge = 1;
    @(negedge clk); stop = 0; bus_edge = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit s, input bit r);
    @(negedge clk); bvld = 1; bdat = b; slot = s; rd = r; bus_edge = 1;
    @(negedge clk); bvld = 0; slot = 0; bus_edge = 0;
  endtask

  // idle n cycles, report first cycle with to_rst high and pulse count
  task automatic idle(input int n, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (to_rst) begin cnt++; if (first == 0) first = i; end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    int first, cnt;
    string s = "123456789";
    void'($urandom(32'h5eed_1234));
    {to_en, bus_edge, start, stop, bvld, slot, rd} = '0;
    bdat = '0;
    repeat (3) @(negedge clk);
    // R1
    check(crc == 8'h00 && !to_rst && !pmatch && !perr, "R1", {crc, to_rst, pmatch, perr}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R2 known vector
    do_start();
    for (int i = 0; i < 9; i++) send(s[i], 0, 0);
    check(crc == 8'hF4, "R2 vector", crc, 8'hF4);
    do_stop();

    // random transactions
    for (int t = 0; t < 40; t++) begin
      int len = 1 + ($urandom % 6);
      int kind = $urandom % 3;
      do_start();
      m = 8'h00;
      check(crc == 8'h00 && !perr, "R3 start", crc, 0);
      for (int i = 0; i < len; i++) begin
        logic [7:0] b = 8'($urandom);
        send(b, 0, 0);
        m = m_crc(m, b);
        check(crc == m, "R2 random", crc, m);
        if (($urandom % 8) == 0) begin
          do_start();
          m = 8'h00;
          check(crc == 8'h00, "R3 repeated start", crc, 0);
        end
      end
      if (kind == 0) begin
        send(m, 1, 0);
        check(pmatch && !perr, "R4 match", {pmatch, perr}, 2);
        check(crc == m, "R4 crc hold", crc, m);
        @(negedge clk);
        check(!pmatch, "R4 pulse width", pmatch, 0);
      end else if (kind == 1) begin
        logic [7:0] bad = m ^ (8'h01 << ($urandom % 8));
        send(bad, 1, 0);
        check(perr && !pmatch, "R5 mismatch", {perr, pmatch}, 2);
        check(crc == m, "R4 crc hold bad", crc, m);
      end else begin
        @(negedge clk); rd = 1;
        #1 check(ptx == m, "R6 tx", ptx, m);
        send(8'($urandom), 1, 1);
        check(crc == m && !pmatch && !perr, "R6 read slot", {crc, pmatch, perr}, {m, 2'b00});
        @(negedge clk); rd = 0;
        #1 check(ptx == 8'h00, "R6 tx gated", ptx, 0);
      end
      do_stop();
    end

    // R3 start colliding with a byte
    do_start();
    send(8'hA5, 0, 0);
    @(negedge clk); start = 1; bvld = 1; bdat = 8'h3C; bus_edge = 1;
    @(negedge clk); start = 0; bvld = 0; bus_edge = 0;
    check(crc == 8'h00, "R3 collision", crc, 0);

    // R5 sticky across bytes, cleared by start
    send(8'h11, 0, 0);
    send(8'hFF ^ m_crc(8'h00, 8'h11), 1, 0);
    send(8'h22, 0, 0);
    check(perr, "R5 sticky", perr, 1);
    do_start();
    check(!perr, "R5 clear on start", perr, 0);
    do_stop();

    // R7 disabled
    to_en = 0;
    do_start();
    idle(3 * N, first, cnt);
    check(cnt == 0, "R7 disabled", cnt, 0);
    do_stop();

    // R8 exact cycle
    to_en = 1;
    do_start();
    idle(N + 2, first, cnt);
    check(first == N, "R8 fire cycle", first, N);
    check(cnt == 1, "R8 single pulse", cnt, 1);
    // R10 disarmed after firing
    idle(3 * N, first, cnt);
    check(cnt == 0, "R10 after fire", cnt, 0);

    // R9 restart by edge
    do_start();
    idle(N / 2, first, cnt);
    @(negedge clk); bus_edge = 1;
    @(negedge clk); bus_edge = 0;
    idle(N + 2, first, cnt);
    check(first == N, "R9 restart", first, N);

    // R10 no fire after stop
    do_start();
    idle(N / 2, first, cnt);
    do_stop();
    idle(3 * N, first, cnt);
    check(cnt == 0, "R10 after stop", cnt, 0);

    // R11 timeout clears crc and error
    do_start();
    send(8'h5A, 0, 0);
    send(8'h00 ^ ~m_crc(8'h00, 8'h5A), 1, 0);
    check(perr && crc == m_crc(8'h00, 8'h5A), "R11 setup", {perr, crc}, {1'b1, m_crc(8'h00, 8'h5A)});
    idle(N, first, cnt);
    check(first == N - 1 || first == N, "R11 fired", first, N);
    if (first == N) idle(1, first, cnt);
    else begin idle(1, first, cnt); end
    check(crc == 8'h00 && !perr, "R11 cleared", {crc, perr}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule